// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This unit sits in front of a single-issue pipeline that four hardware thread contexts share. On every clock it picks the thread that issues next and presents the choice as a registered one-hot grant with a valid flag. Each thread says whether it has an instruction ready, and whether that instruction is speculative, meaning it was issued behind a load that was assumed to hit.

Multiply, divide and cache-miss events take a thread out of rotation. The pipeline pulses a per-thread start line when such an operation issues, and a per-thread done line when the result or the miss data returns. Ordinary single-cycle operations never park a thread. Among the threads that can go, non-speculative work wins over speculative work. Within the winning class, the thread that issued least recently is chosen.

Top module: `thread_select`

## Requirements
- R1: After reset no thread is busy, `valid_o` is 0, `grant_o` is 0, and the recency order is thread 0 (least recent), then 1, 2, 3. With all four threads ready, the first grant therefore goes to thread 0.
- R2: `grant_o` is one-hot when `valid_o` is 1 and all zero when `valid_o` is 0. Bit i stands for thread i. The grant reflects the inputs sampled at the previous rising clock edge.
- R3: Among the candidate threads, the one granted least recently is chosen. A grant moves that thread to the most-recent position. A thread issuing without a start pulse stays in rotation.
- R4: A thread whose `ready_i` bit is 0 is never granted. When no thread is eligible, `valid_o` is 0 and the recency order is left unchanged.
- R5: A `ll_start_i` pulse for a thread makes it ineligible in that same cycle, and it stays ineligible until a `ll_done_i` pulse for it has been sampled. It becomes eligible in the cycle after that pulse.
- R6: A `ll_done_i` pulse for a thread that is not busy is ignored. A done pulse and a start pulse for the same thread in the same cycle leave that thread busy.
- R7: A thread whose `spec_i` bit is 1 is not granted while any eligible thread has `spec_i` 0.
- R8: When every eligible thread is speculative, the least recently granted of them is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 4 | Per-thread instruction-ready flags |
| spec_i | input | 4 | Per-thread flag: pending instruction is speculative |
| ll_start_i | input | 4 | Per-thread pulse: a long-latency operation or a load miss begins |
| ll_done_i | input | 4 | Per-thread pulse: that operation completes or the miss data returns |
| grant_o | output | 4 | One-hot issue grant, registered |
| valid_o | output | 1 | A grant is present |

## Verification
Every grant and valid value becomes visible one clock after the inputs that caused it are sampled. Busy state from a start or done pulse affects the choice made in the cycle after the pulse, except that a start pulse also blocks its own cycle. The driver applies each set of inputs on a falling edge and queues the expected grant. The monitor compares 5 ns after the next rising edge, so each result is matched to the exact cycle whose inputs produced it. The recency order is never read directly. It is inferred from the sequence of grants, and sequences of partially-ready threads show whether it was updated or held.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int unsigned TSEL_THREADS = 4;

  function automatic int unsigned id_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tsel_busy.sv
module tsel_busy #(
  parameter int unsigned N_THR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] start_i,
  input  logic [N_THR-1:0] done_i,
  output logic [N_THR-1:0] busy_o
);
  logic [N_THR-1:0] busy_q;

  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    // start wins over a coincident done
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          busy_q[i] <= 1'b0;
      else if (start_i[i])  busy_q[i] <= 1'b1;
      else if (done_i[i])   busy_q[i] <= 1'b0;
    end

    assert_park_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i[i] |=> busy_q[i]);
    assert_done_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q[i] && done_i[i] && !start_i[i]) |=> !busy_q[i]);
    assert_stray_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q[i] && !start_i[i]) |=> !busy_q[i]);
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/tsel_order.sv
module tsel_order #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned IW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] cand_i,
  output logic [IW-1:0]    pick_o,
  output logic             pick_vld_o
);
  // ord_q[0] is least recently granted
  logic [IW-1:0] ord_q   [N_THR];
  logic [IW-1:0] ord_nxt [N_THR];
  logic [IW-1:0] pick;
  logic [IW-1:0] pos;
  logic          found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    pos   = '0;
    for (int k = 0; k < int'(N_THR); k++) begin
      if (!found && cand_i[ord_q[k]]) begin
        found = 1'b1;
        pick  = ord_q[k];
        pos   = IW'(k);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < int'(N_THR); k++) begin
      if (k < int'(pos))             ord_nxt[k] = ord_q[k];
      else if (k < int'(N_THR) - 1)  ord_nxt[k] = ord_q[(k + 1) % int'(N_THR)];
      else                           ord_nxt[k] = pick;
    end
  end

  for (genvar k = 0; k < N_THR; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ord_q[k] <= IW'(k);
      else if (found)  ord_q[k] <= ord_nxt[k];
    end
  end

  assign pick_o     = pick;
  assign pick_vld_o = found;

  logic [N_THR*IW-1:0] ord_flat;
  logic [N_THR-1:0]    seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < int'(N_THR); k++) begin
      ord_flat[k*IW +: IW] = ord_q[k];
      seen[ord_q[k]]       = 1'b1;
    end
  end

  assert_perm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen == {N_THR{1'b1}});
  assert_pick_cand_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld_o |-> cand_i[pick_o]);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pick_vld_o |=> $stable(ord_flat));
  assert_mru_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld_o |=> (ord_q[N_THR-1] == $past(pick_o)));
endmodule

// File: rtl/thread_select.sv
module thread_select #(
  parameter int unsigned N_THR = tsel_pkg::TSEL_THREADS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] ready_i,
  input  logic [N_THR-1:0] spec_i,
  input  logic [N_THR-1:0] ll_start_i,
  input  logic [N_THR-1:0] ll_done_i,
  output logic [N_THR-1:0] grant_o,
  output logic             valid_o
);
  localparam int unsigned IW = tsel_pkg::id_width(N_THR);

  logic [N_THR-1:0] busy, elig, firm, cand;
  logic [IW-1:0]    pick;
  logic             pick_vld;
  logic [N_THR-1:0] grant_q;
  logic             valid_q;

  tsel_busy #(.N_THR(N_THR)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ll_start_i),
    .done_i  (ll_done_i),
    .busy_o  (busy)
  );

  // a thread starting a long op is parked in the same cycle
  assign elig = ready_i & ~busy & ~ll_start_i;
  assign firm = elig & ~spec_i;
  assign cand = (|firm) ? firm : elig;

  tsel_order #(.N_THR(N_THR), .IW(IW)) u_order (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_i     (cand),
    .pick_o     (pick),
    .pick_vld_o (pick_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end else begin
      grant_q <= pick_vld ? (N_THR'(1) << pick) : '0;
      valid_q <= pick_vld;
    end
  end

  assign grant_o = grant_q;
  assign valid_o = valid_q;

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(grant_o));
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (grant_o == '0));
  assert_not_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld |=> ((grant_o & ~$past(ready_i)) == '0));
  assert_no_busy_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld |=> ((grant_o & ($past(busy) | $past(ll_start_i))) == '0));
  assert_spec_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|firm) |=> ((grant_o & $past(spec_i)) == '0));
endmodule

// File: tb/thread_select_test.sv
`timescale 1ns/1ps
module thread_select_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ready = '0, spec = '0, st = '0, dn = '0;
  logic [3:0] grant;
  logic       valid;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic       v;
    logic [3:0] g;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  thread_select uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ready_i    (ready),
    .spec_i     (spec),
    .ll_start_i (st),
    .ll_done_i  (dn),
    .grant_o    (grant),
    .valid_o    (valid)
  );

  task automatic chk(input logic v, input logic [3:0] g, input string tag);
    total++;
    if (valid !== v || grant !== g) begin
      bad++;
      $display("FAIL %s: valid=%0b grant=%b expected valid=%0b grant=%b",
               tag, valid, grant, v, g);
    end
  endtask

  // driver: apply inputs on the falling edge, queue the result due after the next rise
  task automatic step(input logic [3:0] r, input logic [3:0] s, input logic [3:0] a,
                      input logic [3:0] d, input logic v, input logic [3:0] g,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ready = r; spec = s; st = a; dn = d;
    e.v = v; e.g = g; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.v, e.g, e.tag);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: valid=%0b grant=%b expected run to finish", valid, grant);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b0, 4'b0000, "R1 reset state");
    rst_ni = 1'b1;

    // R1/R3: rotation from reset order, plain issue keeps threads in rotation
    step(4'hF, 0, 0, 0, 1, 4'b0001, "R1 first grant thread 0");
    step(4'hF, 0, 0, 0, 1, 4'b0010, "R3 rotate to 1");
    step(4'hF, 0, 0, 0, 1, 4'b0100, "R3 rotate to 2");
    step(4'hF, 0, 0, 0, 1, 4'b1000, "R3 rotate to 3");
    // R3/R4: partial ready
    step(4'b0101, 0, 0, 0, 1, 4'b0001, "R4 ready 0,2 -> 0");
    step(4'b0101, 0, 0, 0, 1, 4'b0100, "R3 ready 0,2 -> 2");
    step(4'b0000, 0, 0, 0, 0, 4'b0000, "R4 none ready");
    step(4'b1010, 0, 0, 0, 1, 4'b0010, "R4 order held -> 1");
    // R5: park thread 3
    step(4'hF, 0, 4'b1000, 0, 1, 4'b0001, "R5 start parks 3 same cycle");
    step(4'hF, 0, 0, 0, 1, 4'b0100, "R5 3 busy -> 2");
    step(4'b1000, 0, 0, 0, 0, 4'b0000, "R5 only busy ready");
    step(4'b1000, 0, 0, 4'b1000, 0, 4'b0000, "R5 done cycle still busy");
    step(4'b1000, 0, 0, 0, 1, 4'b1000, "R5 3 eligible after done");
    // R6: stray done ignored
    step(4'hF, 0, 0, 4'b0001, 1, 4'b0010, "R6 stray done -> 1");
    step(4'b0001, 0, 0, 0, 1, 4'b0001, "R6 thread 0 not busy");
    // R6: start and done together
    step(4'hF, 0, 4'b0100, 0, 1, 4'b1000, "R5 start parks 2 -> 3");
    step(4'b0100, 0, 4'b0100, 4'b0100, 0, 4'b0000, "R6 start+done");
    step(4'b0100, 0, 0, 0, 0, 4'b0000, "R6 still busy after start+done");
    step(4'b0100, 0, 0, 4'b0100, 0, 4'b0000, "R5 done cycle");
    step(4'b0100, 0, 0, 0, 1, 4'b0100, "R5 2 released");
    // R7/R8: speculation
    step(4'hF, 4'b0011, 0, 0, 1, 4'b1000, "R7 non-spec 2,3 -> 3");
    step(4'b0011, 4'b0001, 0, 0, 1, 4'b0010, "R7 non-spec 1 over spec 0");
    step(4'b0011, 4'b0011, 0, 0, 1, 4'b0001, "R8 all spec -> LRU 0");
    step(4'b0110, 4'b0100, 0, 0, 1, 4'b0010, "R7 1 over spec 2");
    step(4'hF, 4'hF, 0, 0, 1, 4'b0100, "R8 all spec -> 2");

    @(negedge clk);
    ready = '0; spec = '0; st = '0; dn = '0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule